// File: doc/BRIEF.md
# Transmit Frame Release Buffer

This block sits between a DMA engine that writes outgoing frame words and a MAC that reads them. Each stored word carries 32 data bits, four byte enables and four framing flags: start of frame, end of frame, insert CRC and insert pad. The block decides when the frame at the head of the buffer may start toward the MAC. The release policy is selectable. One policy releases once enough bytes are waiting. The other waits for a whole frame, or for buffer pressure that would otherwise stall the writer.

Space taken by the frame currently being sent is held until the MAC acknowledges that frame's end. A collision can then rewind the read side to the frame's first word. A frame larger than the buffer still completes: once the buffer is full, sent words are given back early. A later collision in that frame cannot be retried and is reported as an error.

A flush request empties the buffer in one cycle and clears itself. If the flush cuts a transfer short, it raises an underflow pulse.

Top module: `txq_release_ctrl`

## Requirements
- R1: The buffer holds DEPTH words (default 512 words of 4 bytes, 2 KB). `free_words` equals DEPTH minus the words held, and `wr_ready` is low when no word is free. After reset `free_words` equals DEPTH, `wr_ready` is high and `mac_valid` is low.
- R2: With `cfg_sf_mode` = 0, an idle head frame is released the cycle after four times the count of unsent words exceeds `cfg_threshold`, or the cycle after any word with its end-of-frame flag is stored.
- R3: With `cfg_sf_mode` = 1, an idle head frame is released the cycle after any of these holds: a stored end-of-frame word is not yet sent; the words held reach DEPTH minus AFULL_GAP; or DEPTH minus the words held is less than `cfg_burst`.
- R4: Words reach the MAC in write order. Data, byte enables and the four flags appear together with `mac_valid`, and stay stable while `mac_ready` is low.
- R5: A `flush_req` pulse resets all pointers, so `free_words` is DEPTH in the next cycle. `wr_ready` is low for exactly that one cycle and high again after it. Words written earlier are never presented.
- R6: A flush while a frame is being sent drops `mac_valid` and gives a one-cycle `sts_underflow` pulse in the next cycle. A flush while no frame is being sent gives no pulse.
- R7: A `mac_collision` during a send, before the end-of-frame word has been taken, rewinds the read side. The next presented word is the frame's first word, with its start-of-frame flag set.
- R8: After the end-of-frame word is taken, `mac_valid` stays low and the frame's words stay counted as held until `mac_eof_ack` is pulsed. After the acknowledge they are freed, and the next frame may be released.
- R9: If the buffer is full, holds no end-of-frame word and at least one word of the frame has been sent, the sent words are freed so the frame can continue. A collision after that point does not rewind. Instead it gives a one-cycle `sts_retry_err` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sf_mode | input | 1 | 0 = byte-threshold release, 1 = whole-frame release |
| cfg_threshold | input | THR_W (12) | Byte threshold for threshold release |
| cfg_burst | input | BURST_W (10) | Burst length in words that the writer wants room for |
| flush_req | input | 1 | Flush pulse |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Buffer accepts a word |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Write byte enables |
| wr_sof | input | 1 | Word starts a frame |
| wr_eof | input | 1 | Word ends a frame |
| wr_crc_ins | input | 1 | MAC is to append CRC |
| wr_pad_ins | input | 1 | MAC is to pad short frame |
| mac_valid | output | 1 | Word presented to MAC |
| mac_ready | input | 1 | MAC takes the word |
| mac_data | output | 32 | Presented data |
| mac_be | output | 4 | Presented byte enables |
| mac_sof | output | 1 | Presented start-of-frame flag |
| mac_eof | output | 1 | Presented end-of-frame flag |
| mac_crc_ins | output | 1 | Presented CRC-insert flag |
| mac_pad_ins | output | 1 | Presented pad-insert flag |
| mac_collision | input | 1 | MAC collision, retry wanted |
| mac_eof_ack | input | 1 | MAC confirms the frame end |
| free_words | output | $clog2(DEPTH)+1 (10) | Words free for writing |
| sts_underflow | output | 1 | Send cut short by flush |
| sts_retry_err | output | 1 | Collision could not be retried |

## Verification
A flush request and an active send to the MAC can land in the same cycle. In that case the flush must win over the read handshake and turn the cut into an underflow. Each store-and-forward burst sweep ends this way. The buffer fills until the release condition computed for that burst length fires. The flush is then issued in the very next cycle, while a word is still being presented. The cycle after the flush is judged on four results: an underflow pulse, a full free count, a dropped valid and one cycle of write back-pressure. A flush with no send in progress is checked separately and must give no pulse.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int unsigned TXQ_DATA_W = 32;
    localparam int unsigned TXQ_BE_W   = TXQ_DATA_W / 8;

    // One buffered word: payload plus the framing flags that travel with it
    typedef struct packed {
        logic [TXQ_DATA_W-1:0] data;
        logic [TXQ_BE_W-1:0]   be;
        logic                  sof;
        logic                  eof;
        logic                  crc_ins;
        logic                  pad_ins;
    } txq_word_t;

    // Read-side phase of the head frame
    typedef enum logic [1:0] {
        TXQ_IDLE = 2'd0,   // waiting for the release decision
        TXQ_SEND = 2'd1,   // words flowing to the MAC
        TXQ_WAIT = 2'd2    // end word taken, waiting for MAC acknowledge
    } txq_state_e;

endpackage

// File: rtl/txq_ram.sv
module txq_ram
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  txq_word_t                wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output txq_word_t                rdata
);

    txq_word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Head word is visible in the same cycle the read pointer points at it
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/txq_release.sv
module txq_release #(
    parameter int unsigned DEPTH     = 512,
    parameter int unsigned AFULL_GAP = 16,
    parameter int unsigned THR_W     = 12,
    parameter int unsigned BURST_W   = 10
) (
    input  logic                     sf_mode,
    input  logic [THR_W-1:0]         thr,
    input  logic [BURST_W-1:0]       burst,
    input  logic [$clog2(DEPTH):0]   unsent_words,
    input  logic [$clog2(DEPTH):0]   held_words,
    input  logic                     eof_stored,
    output logic                     go
);

    localparam int unsigned BYTES_PER_WORD = 4;
    localparam int unsigned AFULL_LEVEL    = DEPTH - AFULL_GAP;

    logic [31:0] unsent_bytes;
    logic [31:0] room_words;
    logic        thr_crossed;
    logic        near_full;
    logic        burst_short;

    always_comb begin
        unsent_bytes = 32'(unsent_words) * BYTES_PER_WORD;
        room_words   = DEPTH - 32'(held_words);
        thr_crossed  = unsent_bytes > 32'(thr);
        near_full    = 32'(held_words) >= AFULL_LEVEL;
        burst_short  = room_words < 32'(burst);
        if (sf_mode) begin
            go = eof_stored || near_full || burst_short;
        end else begin
            go = eof_stored || thr_crossed;
        end
    end

endmodule

// File: rtl/txq_release_ctrl.sv
module txq_release_ctrl
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH     = 512,
    parameter int unsigned AFULL_GAP = 16,
    parameter int unsigned THR_W     = $clog2(DEPTH) + 3,
    parameter int unsigned BURST_W   = $clog2(DEPTH) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_sf_mode,
    input  logic [THR_W-1:0]         cfg_threshold,
    input  logic [BURST_W-1:0]       cfg_burst,
    input  logic                     flush_req,
    input  logic                     wr_valid,
    output logic                     wr_ready,
    input  logic [31:0]              wr_data,
    input  logic [3:0]               wr_be,
    input  logic                     wr_sof,
    input  logic                     wr_eof,
    input  logic                     wr_crc_ins,
    input  logic                     wr_pad_ins,
    output logic                     mac_valid,
    input  logic                     mac_ready,
    output logic [31:0]              mac_data,
    output logic [3:0]               mac_be,
    output logic                     mac_sof,
    output logic                     mac_eof,
    output logic                     mac_crc_ins,
    output logic                     mac_pad_ins,
    input  logic                     mac_collision,
    input  logic                     mac_eof_ack,
    output logic [$clog2(DEPTH):0]   free_words,
    output logic                     sts_underflow,
    output logic                     sts_retry_err
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] ONE_P   = PW'(1);

    typedef struct packed {
        logic [PW-1:0] wr;      // next write slot
        logic [PW-1:0] rd;      // next word toward the MAC
        logic [PW-1:0] base;    // first word of the head frame, release boundary
        logic [PW-1:0] eofc;    // stored end words not yet taken
        txq_state_e    st;
        logic          lost;    // head frame start given back, no retry possible
        logic          flush;   // one-cycle flush marker
        logic          uf;      // underflow pulse
        logic          rerr;    // retry refused pulse
    } ctl_t;

    ctl_t q, d;

    logic [PW-1:0] held_words;
    logic [PW-1:0] unsent_words;
    logic          wr_fire;
    logic          rd_fire;
    logic          go;
    logic          eof_inc;
    logic          eof_dec;
    txq_word_t     wr_word;
    txq_word_t     rd_word;

    assign held_words   = q.wr - q.base;
    assign unsent_words = q.wr - q.rd;
    assign wr_ready     = !q.flush && (held_words != DEPTH_P);
    assign wr_fire      = wr_valid && wr_ready && !flush_req;
    assign mac_valid    = (q.st == TXQ_SEND) && (unsent_words != '0);
    assign rd_fire      = mac_valid && mac_ready;
    assign free_words   = DEPTH_P - held_words;
    assign eof_inc      = wr_fire && wr_eof;

    assign wr_word = '{data: wr_data, be: wr_be, sof: wr_sof, eof: wr_eof,
                       crc_ins: wr_crc_ins, pad_ins: wr_pad_ins};

    txq_ram #(
        .DEPTH (DEPTH)
    ) ram_i (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (q.wr[AW-1:0]),
        .wdata (wr_word),
        .raddr (q.rd[AW-1:0]),
        .rdata (rd_word)
    );

    txq_release #(
        .DEPTH     (DEPTH),
        .AFULL_GAP (AFULL_GAP),
        .THR_W     (THR_W),
        .BURST_W   (BURST_W)
    ) release_i (
        .sf_mode      (cfg_sf_mode),
        .thr          (cfg_threshold),
        .burst        (cfg_burst),
        .unsent_words (unsent_words),
        .held_words   (held_words),
        .eof_stored   (q.eofc != '0),
        .go           (go)
    );

    assign mac_data      = rd_word.data;
    assign mac_be        = rd_word.be;
    assign mac_sof       = rd_word.sof;
    assign mac_eof       = rd_word.eof;
    assign mac_crc_ins   = rd_word.crc_ins;
    assign mac_pad_ins   = rd_word.pad_ins;
    assign sts_underflow = q.uf;
    assign sts_retry_err = q.rerr;

    always_comb begin
        d       = q;
        d.uf    = 1'b0;
        d.rerr  = 1'b0;
        d.flush = 1'b0;
        eof_dec = 1'b0;
        if (flush_req) begin
            d.wr    = '0;
            d.rd    = '0;
            d.base  = '0;
            d.eofc  = '0;
            d.st    = TXQ_IDLE;
            d.lost  = 1'b0;
            d.flush = 1'b1;
            d.uf    = (q.st == TXQ_SEND);
        end else begin
            if (wr_fire) begin
                d.wr = q.wr + ONE_P;
            end
            case (q.st)
                TXQ_IDLE: begin
                    if (go && (unsent_words != '0)) begin
                        d.st = TXQ_SEND;
                    end
                end
                TXQ_SEND: begin
                    d.rerr = mac_collision && q.lost;
                    if (mac_collision && !q.lost) begin
                        d.rd = q.base;
                    end else if (rd_fire) begin
                        d.rd = q.rd + ONE_P;
                        if (rd_word.eof) begin
                            eof_dec = 1'b1;
                            d.st    = TXQ_WAIT;
                        end
                    end
                    if (!q.lost && (held_words == DEPTH_P) && (q.eofc == '0)
                        && (q.rd != q.base)) begin
                        d.lost = 1'b1;
                    end
                end
                TXQ_WAIT: begin
                    if (mac_eof_ack) begin
                        d.st   = TXQ_IDLE;
                        d.base = q.rd;
                        d.lost = 1'b0;
                    end
                end
                default: d.st = TXQ_IDLE;
            endcase
            d.eofc = q.eofc + PW'(eof_inc) - PW'(eof_dec);
            if (d.lost) begin
                d.base = d.rd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    AST_FLUSH_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && (q.st == TXQ_SEND) |=> sts_underflow && !mac_valid); // R6

    AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !wr_ready && (free_words == DEPTH_P)); // R5

    AST_COLLISION_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TXQ_SEND) && mac_collision && !q.lost && !flush_req
        |=> q.rd == $past(q.base)); // R7

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TXQ_WAIT) && !mac_eof_ack && !flush_req && !q.lost
        |=> $stable(q.base) && !mac_valid); // R8

    AST_RETRY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TXQ_SEND) && mac_collision && q.lost && !flush_req
        |=> sts_retry_err); // R9

    AST_MAC_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mac_valid && !mac_ready && !mac_collision && !flush_req
        |=> mac_valid && $stable(mac_data) && $stable(mac_sof)); // R4

endmodule

// File: tb/txq_release_ctrl_tb.sv
module txq_release_ctrl_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned DEPTH      = 32;
    localparam int unsigned AFULL_GAP  = 4;
    localparam int unsigned THR_W      = 8;
    localparam int unsigned BURST_W    = 6;
    localparam int unsigned PW         = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_sf_mode;
    logic [THR_W-1:0] cfg_threshold;
    logic [BURST_W-1:0] cfg_burst;
    logic             flush_req;
    logic             wr_valid;
    logic             wr_ready;
    logic [31:0]      wr_data;
    logic [3:0]       wr_be;
    logic             wr_sof, wr_eof, wr_crc_ins, wr_pad_ins;
    logic             mac_valid, mac_ready;
    logic [31:0]      mac_data;
    logic [3:0]       mac_be;
    logic             mac_sof, mac_eof, mac_crc_ins, mac_pad_ins;
    logic             mac_collision, mac_eof_ack;
    logic [PW-1:0]    free_words;
    logic             sts_underflow, sts_retry_err;

    int n_chk = 0;
    int n_bad = 0;
    int fid   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txq_release_ctrl #(
        .DEPTH     (DEPTH),
        .AFULL_GAP (AFULL_GAP),
        .THR_W     (THR_W),
        .BURST_W   (BURST_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_sf_mode (cfg_sf_mode), .cfg_threshold (cfg_threshold), .cfg_burst (cfg_burst),
        .flush_req (flush_req),
        .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_data (wr_data), .wr_be (wr_be),
        .wr_sof (wr_sof), .wr_eof (wr_eof), .wr_crc_ins (wr_crc_ins), .wr_pad_ins (wr_pad_ins),
        .mac_valid (mac_valid), .mac_ready (mac_ready), .mac_data (mac_data), .mac_be (mac_be),
        .mac_sof (mac_sof), .mac_eof (mac_eof), .mac_crc_ins (mac_crc_ins), .mac_pad_ins (mac_pad_ins),
        .mac_collision (mac_collision), .mac_eof_ack (mac_eof_ack),
        .free_words (free_words), .sts_underflow (sts_underflow), .sts_retry_err (sts_retry_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input int f, input int i, input bit first, input bit last);
        logic [7:0] fb;
        fb         = 8'(f);
        wr_valid   = 1'b1;
        wr_data    = {8'hA5, fb, 16'(i)};
        wr_be      = last ? 4'h7 : 4'hF;
        wr_sof     = first;
        wr_eof     = last;
        wr_crc_ins = fb[0];
        wr_pad_ins = fb[1];
        cyc();
        wr_valid   = 1'b0;
    endtask

    task automatic expect_word(input string req, input int f, input int i,
                               input bit first, input bit last);
        logic [7:0]  fb;
        logic [63:0] exp;
        logic [63:0] act;
        fb  = 8'(f);
        exp = {23'd0, 1'b1, first, last, fb[0], fb[1], (last ? 4'h7 : 4'hF),
               8'hA5, fb, 16'(i)};
        act = {23'd0, mac_valid, mac_sof, mac_eof, mac_crc_ins, mac_pad_ins, mac_be, mac_data};
        chk(req, act, exp);
    endtask

    task automatic pop(input string req, input int f, input int i,
                       input bit first, input bit last);
        expect_word(req, f, i, first, last);
        mac_ready = 1'b1;
        cyc();
        mac_ready = 1'b0;
    endtask

    task automatic ack();
        mac_eof_ack = 1'b1;
        cyc();
        mac_eof_ack = 1'b0;
    endtask

    task automatic flush_pulse();
        flush_req = 1'b1;
        cyc();
        flush_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_sf_mode = 1'b0; cfg_threshold = '0; cfg_burst = '0;
        flush_req = 1'b0; wr_valid = 1'b0; wr_data = '0; wr_be = '0;
        wr_sof = 1'b0; wr_eof = 1'b0; wr_crc_ins = 1'b0; wr_pad_ins = 1'b0;
        mac_ready = 1'b0; mac_collision = 1'b0; mac_eof_ack = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        chk("R1 reset free_words", 64'(free_words), 64'(DEPTH));
        chk("R1 reset wr_ready", 64'(wr_ready), 64'd1);
        chk("R1 reset mac_valid", 64'(mac_valid), 64'd0);

        // R2 threshold sweep with R4 ordering and R8 hold-until-ack
        cfg_sf_mode = 1'b0;
        for (int thr = 0; thr < 24; thr++) begin
            cfg_threshold = THR_W'(thr);
            fid++;
            for (int i = 0; i < 6; i++) begin
                push(fid, i, i == 0, i == 5);
                cyc();
                chk("R2 threshold release", 64'(mac_valid),
                    64'(((4 * (i + 1)) > thr) || (i == 5)));
            end
            for (int i = 0; i < 6; i++) begin
                pop("R4 word order and flags", fid, i, i == 0, i == 5);
            end
            chk("R8 quiet after end word", 64'(mac_valid), 64'd0);
            chk("R8 space held before ack", 64'(free_words), 64'(DEPTH - 6));
            cyc();
            chk("R8 space still held", 64'(free_words), 64'(DEPTH - 6));
            ack();
            chk("R8 space freed on ack", 64'(free_words), 64'(DEPTH));
        end

        // R8 second frame waits for the first frame's acknowledge
        cfg_threshold = '0;
        fid++;
        push(fid, 0, 1'b1, 1'b0);
        push(fid, 1, 1'b0, 1'b1);
        push(fid + 1, 0, 1'b1, 1'b0);
        push(fid + 1, 1, 1'b0, 1'b1);
        pop("R4 frame A word 0", fid, 0, 1'b1, 1'b0);
        pop("R4 frame A word 1", fid, 1, 1'b0, 1'b1);
        chk("R8 frame B held back", 64'(mac_valid), 64'd0);
        ack();
        chk("R8 frame B space kept", 64'(free_words), 64'(DEPTH - 2));
        cyc();
        fid++;
        pop("R8 frame B after ack", fid, 0, 1'b1, 1'b0);
        pop("R8 frame B end", fid, 1, 1'b0, 1'b1);
        ack();

        // R3 store-and-forward sweep over burst length, each ended by a flush (R6)
        cfg_sf_mode = 1'b1;
        for (int b = 0; b <= 12; b++) begin
            int  n;
            bit  rel;
            cfg_burst = BURST_W'(b);
            fid++;
            n   = 0;
            rel = 1'b0;
            while (!rel && n < DEPTH) begin
                push(fid, n, n == 0, 1'b0);
                n++;
                cyc();
                rel = (n >= int'(DEPTH - AFULL_GAP)) || ((int'(DEPTH) - n) < b);
                chk("R3 pressure release", 64'(mac_valid), 64'(rel));
            end
            flush_pulse();
            chk("R6 underflow on flush during send", 64'(sts_underflow), 64'd1);
            chk("R6 valid dropped", 64'(mac_valid), 64'd0);
            chk("R5 flush empties", 64'(free_words), 64'(DEPTH));
            chk("R5 flush blocks writes one cycle", 64'(wr_ready), 64'd0);
            cyc();
            chk("R6 underflow is one pulse", 64'(sts_underflow), 64'd0);
            chk("R5 flush self-clears", 64'(wr_ready), 64'd1);
        end

        // R3 whole frame release
        cfg_burst = '0;
        fid++;
        for (int i = 0; i < 3; i++) begin
            push(fid, i, i == 0, i == 2);
            cyc();
            chk("R3 complete frame release", 64'(mac_valid), 64'(i == 2));
        end
        for (int i = 0; i < 3; i++) begin
            pop("R4 frame order", fid, i, i == 0, i == 2);
        end
        ack();

        // R5 flush while idle: no underflow, stale words gone
        fid++;
        push(fid, 0, 1'b1, 1'b0);
        push(fid, 1, 1'b0, 1'b0);
        cyc();
        chk("R3 partial frame held", 64'(mac_valid), 64'd0);
        flush_pulse();
        chk("R6 no underflow when idle", 64'(sts_underflow), 64'd0);
        chk("R5 idle flush empties", 64'(free_words), 64'(DEPTH));
        chk("R5 idle flush blocks write", 64'(wr_ready), 64'd0);
        cyc();
        chk("R5 idle flush self-clears", 64'(wr_ready), 64'd1);
        fid++;
        push(fid, 0, 1'b1, 1'b1);
        cyc();
        pop("R5 fresh word after flush", fid, 0, 1'b1, 1'b1);
        ack();

        // R7 collision rewinds to the frame start
        cfg_sf_mode = 1'b0;
        cfg_threshold = '0;
        fid++;
        for (int i = 0; i < 5; i++) push(fid, i, i == 0, i == 4);
        cyc();
        for (int i = 0; i < 3; i++) pop("R4 before collision", fid, i, i == 0, 1'b0);
        mac_collision = 1'b1;
        cyc();
        mac_collision = 1'b0;
        expect_word("R7 rewind to first word", fid, 0, 1'b1, 1'b0);
        chk("R7 frame still held", 64'(free_words), 64'(DEPTH - 5));
        chk("R7 no retry error", 64'(sts_retry_err), 64'd0);
        for (int i = 0; i < 5; i++) pop("R7 resend", fid, i, i == 0, i == 4);
        ack();
        chk("R8 freed after resend", 64'(free_words), 64'(DEPTH));

        // R9 frame larger than the buffer
        cfg_sf_mode = 1'b1;
        cfg_burst   = '0;
        fid++;
        for (int i = 0; i < int'(DEPTH - AFULL_GAP); i++) push(fid, i, i == 0, 1'b0);
        cyc();
        chk("R3 almost-full release", 64'(mac_valid), 64'd1);
        for (int i = int'(DEPTH - AFULL_GAP); i < int'(DEPTH); i++) push(fid, i, 1'b0, 1'b0);
        chk("R1 full blocks writes", 64'(wr_ready), 64'd0);
        chk("R1 full free count", 64'(free_words), 64'd0);
        pop("R9 first word of oversize frame", fid, 0, 1'b1, 1'b0);
        cyc();
        chk("R9 sent word given back", 64'(free_words), 64'd1);
        mac_collision = 1'b1;
        cyc();
        mac_collision = 1'b0;
        chk("R9 retry refused", 64'(sts_retry_err), 64'd1);
        expect_word("R9 no rewind", fid, 1, 1'b0, 1'b0);
        cyc();
        chk("R9 retry error is one pulse", 64'(sts_retry_err), 64'd0);
        push(fid, DEPTH, 1'b0, 1'b1);
        for (int i = 1; i <= int'(DEPTH); i++) pop("R9 oversize frame completes", fid, i, 1'b0, i == int'(DEPTH));
        chk("R8 quiet after oversize end", 64'(mac_valid), 64'd0);
        ack();
        chk("R9 all space back", 64'(free_words), 64'(DEPTH));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule